// File: doc/BRIEF.md
# Precomputation-Gated Unsigned Magnitude Comparator

This block registers two unsigned W-bit operands and reports whether the first is strictly greater than the second. It cuts switching in the comparator by looking first at the most significant bit of each operand. If those two bits differ, the top bits alone settle the answer. In that case only the top-bit registers load, and the low-order operand registers keep their old contents. The wide compare logic behind those registers then sees no transitions.

A transfer is offered by raising `in_valid` for one cycle with both operands present. One clock edge later, `out_valid` is high and the outputs show the result and a flag. The flag tells whether the short-cut decided the result. With `in_valid` low, the comparator stays frozen. The low-order register contents are brought out so that the effect of the gating can be seen.

Top module: `prec_cmp`

## Requirements
- R1: While `rst_n` is low and after it is released, before any transfer, `out_valid`, `gt_o`, `pred_hit_o`, `lo_c_o` and `lo_d_o` are all zero.
- R2: On the cycle after a clock edge with `in_valid` high, `out_valid` is 1 and `gt_o` is 1 exactly when `op_c` > `op_d` as unsigned numbers.
- R3: On that cycle `pred_hit_o` is 1 exactly when bit W-1 of `op_c` differs from bit W-1 of `op_d`.
- R4: A transfer whose operand top bits differ leaves `lo_c_o` and `lo_d_o` unchanged.
- R5: A transfer whose operand top bits are equal loads `lo_c_o` with `op_c[W-2:0]` and `lo_d_o` with `op_d[W-2:0]`.
- R6: On the cycle after an edge with `in_valid` low, `out_valid` is 0, and `gt_o`, `pred_hit_o`, `lo_c_o` and `lo_d_o` keep their previous values.
- R7: Equal operands give `gt_o` = 0 and `pred_hit_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand strobe |
| op_c | input | W | First operand (unsigned) |
| op_d | input | W | Second operand (unsigned) |
| out_valid | output | 1 | Result valid, one cycle after strobe |
| gt_o | output | 1 | op_c > op_d for the last transfer |
| pred_hit_o | output | 1 | Top bits alone decided the result |
| lo_c_o | output | W-1 | Low-order register of op_c feeding the full compare |
| lo_d_o | output | W-1 | Low-order register of op_d feeding the full compare |

## Verification
The stimulus is built from several pattern families:

- **Uniform random operands.** These mix predicted and full-compare transfers about evenly. They test the overall greater-than result.
- **Forced differing top bits.** These test the short-cut answer. They also show whether the low-order registers really held still.
- **Forced equal top bits.** These send every decision through the full compare of the low bits. They catch loading or ordering errors in that path.
- **Equal operands and extremes.** These probe the strict-inequality boundary. Examples are all ones against zero, and values that differ only in the least significant bit.
- **Idle gaps between strobes.** These separate "held" behaviour from "recomputed" behaviour.

// File: rtl/prec_cmp.sv
module prec_cmp #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] op_c,
  input  logic [W-1:0] op_d,
  output logic         out_valid,
  output logic         gt_o,
  output logic         pred_hit_o,
  output logic [W-2:0] lo_c_o,
  output logic [W-2:0] lo_d_o
);
  localparam int LW = W - 1;

  // predictors on the top bits: mutually exclusive
  wire pred_gt = op_c[W-1] & ~op_d[W-1];
  wire pred_lt = ~op_c[W-1] & op_d[W-1];
  wire lo_load = in_valid & ~(pred_gt | pred_lt);

  logic          top_c_q, top_d_q, hit_q, vld_q;
  logic [LW-1:0] lo_c_q, lo_d_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      top_c_q <= 1'b0;
      top_d_q <= 1'b0;
      hit_q   <= 1'b0;
      vld_q   <= 1'b0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) begin
        top_c_q <= op_c[W-1];
        top_d_q <= op_d[W-1];
        hit_q   <= pred_gt | pred_lt;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_c_q <= '0;
      lo_d_q <= '0;
    end else if (lo_load) begin
      lo_c_q <= op_c[LW-1:0];
      lo_d_q <= op_d[LW-1:0];
    end
  end

  assign out_valid  = vld_q;
  assign pred_hit_o = hit_q;
  assign gt_o       = hit_q ? (top_c_q & ~top_d_q) : (lo_c_q > lo_d_q);
  assign lo_c_o     = lo_c_q;
  assign lo_d_o     = lo_d_q;
endmodule

// File: rtl/prec_cmp_chk.sv
module prec_cmp_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [W-1:0] op_c,
  input logic [W-1:0] op_d,
  input logic         out_valid,
  input logic         gt_o,
  input logic         pred_hit_o,
  input logic [W-2:0] lo_c_o,
  input logic [W-2:0] lo_d_o
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && !gt_o && !pred_hit_o && lo_c_o == '0 && lo_d_o == '0));

  // R2
  gt_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_valid && gt_o == ($past(op_c) > $past(op_d))));

  // R3
  hit_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (pred_hit_o == ($past(op_c[W-1]) ^ $past(op_d[W-1]))));

  // R4
  lo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op_c[W-1] != op_d[W-1])) |=> ($stable(lo_c_o) && $stable(lo_d_o)));

  // R5
  lo_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op_c[W-1] == op_d[W-1])) |=>
      (lo_c_o == $past(op_c[W-2:0]) && lo_d_o == $past(op_d[W-2:0])));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && $past(rst_n)) |=>
      (!out_valid && $stable(gt_o) && $stable(pred_hit_o) && $stable(lo_c_o) && $stable(lo_d_o)));

  // R7
  equal_ops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_c == op_d) |=> (!gt_o && !pred_hit_o));
endmodule

bind prec_cmp prec_cmp_chk #(.W(W)) chk_i (.*);

// File: tb/prec_cmp_tb_top.sv
`timescale 1ns/1ps
module prec_cmp_tb_top;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [W-1:0] op_c = '0, op_d = '0;
  logic         out_valid, gt_o, pred_hit_o;
  logic [W-2:0] lo_c_o, lo_d_o;

  int checks = 0, fails = 0;
  bit exp_vld = 0, exp_gt = 0, exp_hit = 0;
  logic [W-2:0] exp_lo_c = '0, exp_lo_d = '0;

  always #2.5 clk = ~clk;

  prec_cmp #(.W(W)) dut_i (.*);

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk(req, "out_valid", out_valid, exp_vld);
    chk(req, "gt_o", gt_o, exp_gt);
    chk(req, "pred_hit_o", pred_hit_o, exp_hit);
    chk(req, "lo_c_o", lo_c_o, exp_lo_c);
    chk(req, "lo_d_o", lo_d_o, exp_lo_d);
  endtask

  // one transfer (or idle cycle), then compare on the following negedge
  task automatic step(input bit v, input logic [W-1:0] c, input logic [W-1:0] d, input string req);
    in_valid = v; op_c = c; op_d = d;
    @(posedge clk);
    exp_vld = v;
    if (v) begin
      exp_gt  = (int'(c) > int'(d));
      exp_hit = (c[W-1] != d[W-1]);
      if (!exp_hit) begin
        exp_lo_c = c[W-2:0];
        exp_lo_d = d[W-2:0];
      end
    end
    @(negedge clk);
    check_all(req);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    // R7: equal operands, both top-bit halves
    step(1, 16'h1234, 16'h1234, "R7");
    step(1, 16'hF00D, 16'hF00D, "R7");
    // R2 boundaries on the low bits
    step(1, 16'h0001, 16'h0000, "R2");
    step(1, 16'h7FFE, 16'h7FFF, "R2");
    // R3/R4: top bits differ, low lanes must hold at 7FFE/7FFF
    step(1, 16'hFFFF, 16'h0000, "R4");
    step(1, 16'h0000, 16'h8000, "R3");
    // R6 idle gap holding a predicted result
    step(0, 16'hAAAA, 16'h5555, "R6");
    step(0, 16'h0000, 16'hFFFF, "R6");
    // R5 equal-top reload
    step(1, 16'h8001, 16'hFFFE, "R5");
    step(0, 16'h1111, 16'h2222, "R6");

    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] c = W'($urandom), d = W'($urandom);
      step(1, c, d, "R2");
    end
    for (int i = 0; i < 200; i++) begin
      logic [W-1:0] c = W'($urandom), d = W'($urandom);
      d[W-1] = ~c[W-1];
      step(1, c, d, "R4");
    end
    for (int i = 0; i < 200; i++) begin
      logic [W-1:0] c = W'($urandom), d = W'($urandom);
      d[W-1] = c[W-1];
      step(1, c, d, "R5");
    end
    for (int i = 0; i < 200; i++) begin
      logic [W-1:0] c = W'($urandom), d = W'($urandom);
      step(($urandom % 3) != 0, c, d, "R6");
    end
    finish_run();
  end
endmodule